// File: doc/BRIEF.md
# Synchronous Burst SRAM with Address-Status Control

This block is a synthesizable model of a single-port synchronous static RAM built from 32-bit words. Every input is captured on the rising clock edge: the address, the write data, the three chip enables, the write controls, the two address strobes and the advance input. The output enable is the only input that acts at once. The data bus is a shared tri-state bus. The bench drives write data onto it, and the block drives read data back onto the same wires.

A transfer begins when one of two address strobes loads an external address. The processor strobe always starts a read. It is recognised only while the primary chip enable is asserted, and it takes priority over the controller strobe. The controller strobe starts a read or a write, depending on the write controls sampled in the same cycle. After a load, the two low address bits come from an internal burst counter. Each cycle in which advance is low steps the counter through the aligned four-word group in linear order. A cycle with advance high is a wait: the access repeats at the same word. Chip enables are sampled only on a load. Together they decide whether the burst that follows is selected.

A write either covers the full word (global write) or only the byte lanes picked by the byte-write enable and the four byte selects. Read data is registered: it appears on the bus one clock after the address is registered. The depth is a parameter, with a default of 1024 words so that the default build stays small.

Top module: `sburst_ram`

## Requirements
- R1: While reset is asserted and after it is released, no access takes place until an address load, so the block never drives the data bus.
- R2: A processor-strobe load (proc_ld_n low, sel0_n low, sel1_n low, sel2 high) always starts a read, and the memory is left unchanged whatever gw_n, bwe_n, bsel_n and the bus carry.
- R3: A controller-strobe load (ctrl_ld_n low) starts a write when gw_n or bwe_n is low, and a read otherwise.
- R4: When both strobes are low and sel0_n is low, the processor strobe wins: the cycle is a read and nothing is written.
- R5: With sel0_n high, a low proc_ld_n is ignored. An ongoing burst continues, and a low ctrl_ld_n in the same cycle still performs its load.
- R6: Chip-enable pins are ignored in cycles without a load. A selected burst keeps running with all enables deasserted, and a deselected device neither reads nor writes until the next load.
- R7: The device is selected only if sel0_n is low, sel1_n is low and sel2 is high at the load. Any other combination deselects it.
- R8: A continuation cycle with adv_n low adds one, modulo 4, to address bits 1:0 and leaves the upper bits unchanged, so a burst from word 2 visits 2, 3, 0, 1 of its aligned group.
- R9: A continuation cycle with adv_n high is a wait: it accesses the same word again.
- R10: gw_n low writes all 32 bits, whatever bwe_n and bsel_n are.
- R11: With gw_n high and bwe_n low, bsel_n[i] low writes bits 8i+7:8i, and lanes whose select is high keep their contents.
- R12: Data of a read registered at clock edge k is on the bus from edge k+1 until edge k+2.
- R13: The bus is high impedance whenever oe_n is high, and becomes driven without waiting for a clock edge once oe_n falls while read data is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except oe_n are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addr_i | input | AW | External word address, loaded on a strobe |
| proc_ld_n | input | 1 | Processor address strobe, active low, read only |
| ctrl_ld_n | input | 1 | Controller address strobe, active low, read or write |
| adv_n | input | 1 | Burst advance, active low; high inserts a wait |
| gw_n | input | 1 | Global write, active low, all four lanes |
| bwe_n | input | 1 | Byte-write enable, active low, gates bsel_n |
| bsel_n | input | 4 | Byte selects, active low, bit i for bits 8i+7:8i |
| sel0_n | input | 1 | Primary chip enable, active low, also gates proc_ld_n |
| sel1_n | input | 1 | Secondary chip enable, active low |
| sel2 | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | 32 | Bidirectional data bus |

## Verification
Bursts are run from each position inside a four-word group, for both reads and writes, so the wrap of the low bits is separated from a plain increment. Wait cycles inside a read burst check that the word repeats rather than moves on. Full-word, partial-lane and zero-lane writes, with gw_n and bwe_n set both ways, show which control decides each lane. Strobe collisions, a processor strobe with the primary enable off, and loads with one enable wrong are each followed by a read-back or a bus-release check, which shows whether a load happened, whether it selected the device and whether memory was touched. Toggling oe_n in the middle of a cycle separates the asynchronous enable from the registered read path.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;
   // kind of access performed at a clock edge
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/sbr_lane_mask.sv
`timescale 1ns/1ps
module sbr_lane_mask #(
   parameter int unsigned LANES = 4
) (
   input  logic             gw_n_i,
   input  logic             bwe_n_i,
   input  logic [LANES-1:0] bsel_n_i,
   output logic             wr_req_o,
   output logic [LANES-1:0] lane_we_o
);
   if (LANES < 1) begin : g_bad_lanes
      $error("sbr_lane_mask: LANES must be at least 1");
   end

   assign wr_req_o = !gw_n_i || !bwe_n_i;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_we_o[l] = !gw_n_i || (!bwe_n_i && !bsel_n_i[l]);
   end
endmodule

// File: rtl/sbr_addr_ctl.sv
`timescale 1ns/1ps
module sbr_addr_ctl
   import sbr_pkg::*;
#(
   parameter int unsigned AW        = 10,
   parameter int unsigned BURST_LEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ld_addr_i,
   input  logic          proc_stb_n_i,
   input  logic          ctrl_stb_n_i,
   input  logic          adv_n_i,
   input  logic          wr_req_i,
   input  logic          prim_ok_i,
   input  logic          sel_ok_i,
   output acc_kind_e     acc_kind_o,
   output logic [AW-1:0] acc_addr_o
);
   localparam int unsigned CW = $clog2(BURST_LEN);

   if (BURST_LEN < 2 || (1 << CW) != BURST_LEN) begin : g_bad_burst
      $error("sbr_addr_ctl: BURST_LEN must be a power of two, at least 2");
   end
   if (AW <= CW) begin : g_bad_aw
      $error("sbr_addr_ctl: address narrower than the burst counter");
   end

   logic          sel_q;
   logic [AW-1:0] cur_q;
   logic          proc_go, ctrl_go, load;
   logic          nxt_sel;
   logic [AW-1:0] nxt_addr;
   logic [CW-1:0] cnt_nxt;

   // processor strobe needs the primary enable and beats the controller strobe
   assign proc_go = !proc_stb_n_i && prim_ok_i;
   assign ctrl_go = !ctrl_stb_n_i && !proc_go;
   assign load    = proc_go || ctrl_go;

   always_comb begin
      cnt_nxt = adv_n_i ? cur_q[CW-1:0] : cur_q[CW-1:0] + 1'b1;
      if (load) begin
         nxt_sel  = sel_ok_i;
         nxt_addr = ld_addr_i;
      end else begin
         nxt_sel  = sel_q;
         nxt_addr = {cur_q[AW-1:CW], cnt_nxt};
      end
      if (!nxt_sel)      acc_kind_o = ACC_IDLE;
      else if (proc_go)  acc_kind_o = ACC_READ;
      else if (wr_req_i) acc_kind_o = ACC_WRITE;
      else               acc_kind_o = ACC_READ;
   end

   assign acc_addr_o = nxt_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         cur_q <= '0;
      end else begin
         sel_q <= nxt_sel;
         cur_q <= nxt_addr;
      end
   end

   assert_adv_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && proc_stb_n_i && ctrl_stb_n_i && !adv_n_i) |=>
         (cur_q[CW-1:0] == CW'($past(cur_q[CW-1:0]) + 1'b1)) &&
         (cur_q[AW-1:CW] == $past(cur_q[AW-1:CW])));

   assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_stb_n_i && ctrl_stb_n_i && adv_n_i) |=> $stable(cur_q));

   assert_sel_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_stb_n_i && ctrl_stb_n_i) |=> $stable(sel_q));
endmodule

// File: rtl/sbr_store.sv
`timescale 1ns/1ps
module sbr_store
   import sbr_pkg::*;
#(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned DATA_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  acc_kind_e                  acc_kind_i,
   input  logic [$clog2(DEPTH)-1:0]   acc_addr_i,
   input  logic [DATA_W-1:0]          wdata_i,
   input  logic [DATA_W/LANE_W-1:0]   lane_we_i,
   input  logic                       oe_n_i,
   output logic [DATA_W-1:0]          rdata_o,
   output logic                       drive_o
);
   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned LANES = DATA_W / LANE_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic              rd_pend_q, act_q;
   logic [AW-1:0]     rd_addr_q;
   logic [DATA_W-1:0] q_q;

   always_ff @(posedge clk) begin
      if (acc_kind_i == ACC_WRITE) begin
         for (int l = 0; l < LANES; l++) begin
            if (lane_we_i[l]) mem[acc_addr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
         end
      end
   end

   // stage 1: register the read address, stage 2: register the word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pend_q <= 1'b0;
         act_q     <= 1'b0;
         rd_addr_q <= '0;
      end else begin
         rd_pend_q <= (acc_kind_i == ACC_READ);
         act_q     <= rd_pend_q;
         rd_addr_q <= acc_addr_i;
      end
   end

   always_ff @(posedge clk) q_q <= mem[rd_addr_q];

   assign rdata_o = q_q;
   assign drive_o = act_q && !oe_n_i;

   assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
      drive_o |-> $past(acc_kind_i, 2) == ACC_READ);

   for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      assert_lane_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_kind_i == ACC_WRITE && !lane_we_i[l]) |=>
            mem[$past(acc_addr_i)][l*LANE_W +: LANE_W] ==
            $past(mem[acc_addr_i][l*LANE_W +: LANE_W]));
      assert_lane_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_kind_i == ACC_WRITE && lane_we_i[l]) |=>
            mem[$past(acc_addr_i)][l*LANE_W +: LANE_W] ==
            $past(wdata_i[l*LANE_W +: LANE_W]));
   end
endmodule

// File: rtl/sburst_ram.sv
`timescale 1ns/1ps
module sburst_ram
   import sbr_pkg::*;
#(
   parameter int unsigned DEPTH     = 1024,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BURST_LEN = 4,
   localparam int unsigned AW       = $clog2(DEPTH),
   localparam int unsigned LANES    = DATA_W / LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr_i,
   input  logic             proc_ld_n,
   input  logic             ctrl_ld_n,
   input  logic             adv_n,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bsel_n,
   input  logic             sel0_n,
   input  logic             sel1_n,
   input  logic             sel2,
   input  logic             oe_n,
   inout  wire [DATA_W-1:0] dq
);
   if (DATA_W == 0 || DATA_W % LANE_W != 0) begin : g_bad_width
      $error("sburst_ram: DATA_W must be a non-zero multiple of the lane width");
   end
   if (DEPTH < BURST_LEN || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("sburst_ram: DEPTH must be a power of two no smaller than BURST_LEN");
   end

   acc_kind_e         acc_kind;
   logic [AW-1:0]     acc_addr;
   logic              wr_req;
   logic [LANES-1:0]  lane_we;
   logic [DATA_W-1:0] rdata;
   logic              drive;
   logic              sel_ok;

   assign sel_ok = !sel0_n && !sel1_n && sel2;

   sbr_lane_mask #(.LANES(LANES)) u_mask (
      .gw_n_i    (gw_n),
      .bwe_n_i   (bwe_n),
      .bsel_n_i  (bsel_n),
      .wr_req_o  (wr_req),
      .lane_we_o (lane_we)
   );

   sbr_addr_ctl #(.AW(AW), .BURST_LEN(BURST_LEN)) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ld_addr_i    (addr_i),
      .proc_stb_n_i (proc_ld_n),
      .ctrl_stb_n_i (ctrl_ld_n),
      .adv_n_i      (adv_n),
      .wr_req_i     (wr_req),
      .prim_ok_i    (!sel0_n),
      .sel_ok_i     (sel_ok),
      .acc_kind_o   (acc_kind),
      .acc_addr_o   (acc_addr)
   );

   sbr_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_kind_i (acc_kind),
      .acc_addr_i (acc_addr),
      .wdata_i    (dq),
      .lane_we_i  (lane_we),
      .oe_n_i     (oe_n),
      .rdata_o    (rdata),
      .drive_o    (drive)
   );

   assign dq = drive ? rdata : {DATA_W{1'bz}};

   assert_proc_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_ld_n && !sel0_n && !sel1_n && sel2) |-> acc_kind == ACC_READ);

   assert_proc_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_ld_n && !ctrl_ld_n && !sel0_n) |-> acc_kind != ACC_WRITE);

   assert_desel_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((!ctrl_ld_n || (!proc_ld_n && !sel0_n)) && (sel0_n || sel1_n || !sel2))
         |-> acc_kind == ACC_IDLE);

   assert_quiet_reset_R1: assert property (@(posedge clk)
      !rst_n |=> !drive);
endmodule

// File: tb/sburst_ram_tb.sv
`timescale 1ns/1ps
module sburst_ram_tb;
   localparam int unsigned AW = 10;
   localparam logic [31:0] PAT = 32'hC3C3_3C3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic        proc_ld_n = 1'b1, ctrl_ld_n = 1'b1, adv_n = 1'b1;
   logic        gw_n = 1'b1, bwe_n = 1'b1;
   logic [3:0]  bsel_n = 4'hF;
   logic        sel0_n = 1'b1, sel1_n = 1'b1, sel2 = 1'b0;
   logic        oe_n = 1'b0;
   logic        tb_drv = 1'b1;
   logic [31:0] tb_dat = PAT;
   wire  [31:0] dq;

   int n_chk = 0, n_err = 0, cyc_n = 0;
   logic [31:0] mdl [1024];
   int    q_due[$];
   logic [31:0] q_dat[$];
   string q_tag[$];

   assign dq = tb_drv ? tb_dat : 32'hzzzz_zzzz;

   sburst_ram u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .proc_ld_n(proc_ld_n),
      .ctrl_ld_n(ctrl_ld_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
      .bsel_n(bsel_n), .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2(sel2),
      .oe_n(oe_n), .dq(dq)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc_n <= cyc_n + 1;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard when an expected read is due on the bus
   always @(negedge clk) begin
      if (q_due.size() > 0 && q_due[0] == cyc_n) begin
         logic [31:0] e;
         string t;
         e = q_dat.pop_front();
         t = q_tag.pop_front();
         void'(q_due.pop_front());
         chk(dq, e, t);
      end
   end

   // one cycle of stimulus, captured at the next rising edge
   task automatic drv(input logic pn, cn, an, gn, bn, input logic [3:0] bs,
                      input logic s0n, s1n, s2, input logic [AW-1:0] a,
                      input logic oen, td, input logic [31:0] d);
      @(posedge clk); #1;
      proc_ld_n = pn; ctrl_ld_n = cn; adv_n = an; gw_n = gn; bwe_n = bn;
      bsel_n = bs; sel0_n = s0n; sel1_n = s1n; sel2 = s2; addr_i = a;
      oe_n = oen; tb_drv = td; tb_dat = d;
   endtask

   task automatic push_rd(input logic [31:0] e, input string tag);
      q_due.push_back(cyc_n + 2);
      q_dat.push_back(e);
      q_tag.push_back(tag);
   endtask

   // lane rules of R10 / R11
   task automatic mdl_wr(input int a, input logic gn, bn, input logic [3:0] bs, input logic [31:0] d);
      for (int l = 0; l < 4; l++)
         if (!gn || (!bn && !bs[l])) mdl[a][l*8 +: 8] = d[l*8 +: 8];
   endtask

   task automatic idle();
      drv(1,1,1,1,1,4'hF, 1,1,0, '0, 0,0, 32'h0);
   endtask

   // drives a pattern and checks that the access two calls earlier left the bus free
   task automatic hz_step(input string tag);
      drv(1,1,1,1,1,4'hF, 1,1,0, '0, 0,1, PAT);
      @(negedge clk); #1;
      chk(dq, PAT, tag);
   endtask

   task automatic ctrl_wr(input int a, input logic gn, bn, input logic [3:0] bs, input logic [31:0] d);
      drv(1,0,1,gn,bn,bs, 0,0,1, AW'(a), 1,1, d);
      mdl_wr(a, gn, bn, bs, d);
   endtask

   task automatic cont_wr(input int a, input logic [31:0] d);
      drv(1,1,0,0,1,4'hF, 1,1,0, '0, 1,1, d);
      mdl_wr(a, 1'b0, 1'b1, 4'hF, d);
   endtask

   task automatic proc_rd(input int a, input string tag);
      drv(0,1,1,1,1,4'hF, 0,0,1, AW'(a), 0,0, 32'h0);
      push_rd(mdl[a], tag);
   endtask

   task automatic ctrl_rd(input int a, input string tag);
      drv(1,0,1,1,1,4'hF, 0,0,1, AW'(a), 0,0, 32'h0);
      push_rd(mdl[a], tag);
   endtask

   // continuation read with every chip enable deasserted (R6)
   task automatic cont_rd(input logic an, input int a, input string tag);
      drv(1,1,an,1,1,4'hF, 1,1,0, '0, 0,0, 32'h0);
      push_rd(mdl[a], tag);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mdl[i] = 32'h0;
      // R1: reset, bus never driven
      hz_step("R1 in reset");
      hz_step("R1 in reset");
      rst_n = 1'b1;
      hz_step("R1 after reset");
      hz_step("R1 after reset");

      // R3 R10 R8: controller write burst from word 2 wraps to 0
      ctrl_wr(32'h12, 0, 1, 4'hF, 32'h1200_0012);
      cont_wr(32'h13, 32'h1300_0013);
      cont_wr(32'h10, 32'h1000_0010);
      cont_wr(32'h11, 32'h1100_0011);
      idle(); idle();
      // R2 R12 R8 R6: processor read burst 1,2,3,0,1
      proc_rd(32'h11, "R2 R12 proc read word 1");
      cont_rd(0, 32'h12, "R8 R6 burst step 2");
      cont_rd(0, 32'h13, "R8 burst step 3");
      cont_rd(0, 32'h10, "R8 burst wrap to 0");
      cont_rd(0, 32'h11, "R8 burst back to 1");
      idle(); idle();
      // R9: wait cycle repeats the word
      proc_rd(32'h12, "R9 load word 2");
      cont_rd(1, 32'h12, "R9 wait repeats word 2");
      cont_rd(0, 32'h13, "R9 advance after wait");
      idle(); idle();

      // R11 R10: lane masking
      ctrl_wr(32'h30, 0, 1, 4'hF, 32'hAAAA_AAAA);
      ctrl_wr(32'h30, 1, 0, 4'b1010, 32'h1122_3344);
      ctrl_wr(32'h31, 0, 1, 4'hF, 32'h5555_5555);
      ctrl_wr(32'h31, 0, 0, 4'hF, 32'h1234_5678);
      ctrl_wr(32'h32, 0, 1, 4'hF, 32'h0);
      ctrl_wr(32'h32, 1, 0, 4'b0111, 32'hDEAD_BEEF);
      chk(mdl[32'h30], 32'hAA22_AA44, "R11 model lanes 0 and 2");
      ctrl_rd(32'h30, "R11 lanes 0 and 2 written");
      cont_rd(0, 32'h31, "R10 gw overrides bwe and bsel");
      cont_rd(0, 32'h32, "R11 lane 3 only");
      idle(); idle();

      // R2: processor load ignores write controls and bus data
      drv(0,1,1,0,0,4'h0, 0,0,1, AW'(32'h30), 1,1, 32'hFFFF_FFFF);
      push_rd(32'hAA22_AA44, "R2 proc load reads despite gw_n low");
      idle(); idle();
      ctrl_rd(32'h30, "R2 word unchanged after proc load");
      idle(); idle();

      // R4: both strobes low, processor wins
      drv(0,0,1,0,1,4'hF, 0,0,1, AW'(32'h31), 1,1, 32'h0);
      push_rd(32'h1234_5678, "R4 proc strobe wins read");
      idle(); idle();
      ctrl_rd(32'h31, "R4 no write from collision");
      idle(); idle();

      // R5: proc strobe ignored with sel0_n high
      proc_rd(32'h10, "R5 load word 0");
      drv(0,1,0,1,1,4'hF, 1,0,1, AW'(32'h20), 0,0, 32'h0);
      push_rd(mdl[32'h11], "R5 ignored strobe, burst goes on");
      idle(); idle();
      proc_rd(32'h10, "R5 load before ctrl deselect");
      drv(0,0,0,1,1,4'hF, 1,0,1, AW'(32'h20), 0,0, 32'h0);
      idle();
      hz_step("R5 ctrl load taken and deselects");
      hz_step("R6 deselected wait stays idle");

      // R7 R6: load with sel2 low, writes that follow are dropped
      drv(1,0,1,0,1,4'hF, 0,0,0, AW'(32'h30), 1,1, 32'hFFFF_FFFF);
      drv(1,1,0,0,1,4'hF, 0,0,1, '0, 1,1, 32'hFFFF_FFFF);
      drv(1,1,0,0,1,4'hF, 0,0,1, '0, 1,1, 32'hFFFF_FFFF);
      idle();
      ctrl_rd(32'h30, "R7 word 0x30 kept");
      cont_rd(0, 32'h31, "R6 word 0x31 kept");
      idle(); idle();
      drv(1,0,1,1,1,4'hF, 0,1,1, AW'(32'h30), 0,0, 32'h0);
      idle();
      hz_step("R7 sel1_n high deselects");

      // R13: output enable gates the bus without a clock edge
      drv(0,1,1,1,1,4'hF, 0,0,1, AW'(32'h10), 0,0, 32'h0);
      idle();
      drv(1,1,1,1,1,4'hF, 1,1,0, '0, 1,1, PAT);
      @(negedge clk); #1;
      chk(dq, PAT, "R13 oe_n high keeps bus free");
      oe_n = 1'b0; tb_drv = 1'b0;
      #1;
      chk(dq, mdl[32'h10], "R13 oe_n low drives at once");
      idle(); idle(); idle(); idle();

      chk(32'(q_due.size()), 32'd0, "R12 all reads seen");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule